// File: doc/BRIEF.md
# Identifier-Byte Acceptance Filter for a Vehicle-Bus Receiver

This block sits between the symbol decoder of a byte-oriented serial vehicle-bus receiver (J1850 style) and the receive data register with its status flags. It holds a 256-bit acceptance map, one bit per possible identifier value. Software loads the map through thirty-two 8-bit registers. The first byte after each start-of-frame is the frame identifier. Its map bit decides whether that frame reaches the receiver's data path or is muted until the next end-of-frame-minimum symbol.

The block takes decoded bus events as single-cycle strobes: start of frame, byte received, end-of-frame-minimum, break, idle, overrun, end of data, CRC error, invalid frame and invalid bit. It also takes two levels. One shows that the local node is transmitting. The other is a sleep request. Every output is a registered strobe issued one clock after the event that caused it. In a muted frame, the set of strobes still forwarded depends on whether the frame came from another node or from the local transmitter.

The state machine has six states:

| State | Meaning |
|---|---|
| S_IDLE | Between frames |
| S_WAIT_ID | Start of frame seen, identifier not yet received |
| S_PASS | Frame accepted |
| S_SLEEP | Accepted frame in which a sleep request was seen |
| S_DROP_RX | Rejected frame from another node |
| S_DROP_TX | Rejected frame from the local transmitter |

Transitions:
- S_IDLE goes to S_WAIT_ID on start of frame.
- S_WAIT_ID on an identifier byte goes to S_PASS if the map bit is 1. If the bit is 0, it goes to S_DROP_TX when transmitting and to S_DROP_RX otherwise.
- S_PASS goes to S_SLEEP on a sleep request.
- Every state other than S_IDLE returns to S_IDLE on end-of-frame-minimum.

Top module: `idmsg_filter`

## Requirements
- R1: After reset, all output strobes are 0 and every map bit is 0, so every identifier is rejected.
- R2: A write with address r and data d loads map bits 8r to 8r+7. Identifier value 8r+b uses bit b of register r. A write is seen by every identifier lookup made in a later cycle.
- R3: The first byte after a start of frame is the identifier. When its map bit is 1, `rx_wr` pulses one cycle later and `rx_data` holds the identifier. Bytes received in S_IDLE are never transferred.
- R4: In an accepted frame, each later byte is transferred the same way. Overrun, end-of-data and error events are forwarded one cycle later.
- R5: In a rejected frame from another node, there are no transfers and no overrun, end-of-data, CRC, invalid-frame or invalid-bit strobes until end-of-frame-minimum.
- R6: Break and idle events are forwarded one cycle later in every state.
- R7: CRC, invalid-frame and invalid-bit events that arrive before the identifier comparison (in S_IDLE or S_WAIT_ID) are forwarded.
- R8: End-of-frame-minimum returns the machine to S_IDLE from any state. The next frame gets a fresh lookup.
- R9: When the local node sends a rejected identifier (`tx_active` high at the identifier byte), there are no transfers and no overrun or end-of-data strobes. CRC, invalid-frame, invalid-bit and break strobes are still forwarded.
- R10: When the local node sends an accepted identifier, every byte it sends is looped into `rx_data` with an `rx_wr` pulse.
- R11: In an accepted frame, `sleep_req` suppresses the byte of the cycle in which it is first seen. It also suppresses every later byte, overrun and end-of-data strobe until end-of-frame-minimum, even after `sleep_req` falls. Error strobes are still forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Map register write strobe |
| cfg_addr | input | 5 | Map register index |
| cfg_wdata | input | 8 | Map register write data |
| tx_active | input | 1 | Local node is transmitting |
| sleep_req | input | 1 | Ignore the rest of the current accepted frame |
| ev_sof | input | 1 | Start of frame strobe |
| ev_byte | input | 1 | Byte received strobe |
| ev_data | input | 8 | Received byte value |
| ev_eofmin | input | 1 | End-of-frame-minimum strobe |
| ev_break | input | 1 | Break strobe |
| ev_idle | input | 1 | Bus idle strobe |
| ev_overrun | input | 1 | Receive overrun strobe |
| ev_eod | input | 1 | End-of-data strobe |
| ev_err_crc | input | 1 | CRC error strobe |
| ev_err_frame | input | 1 | Invalid frame strobe |
| ev_err_bit | input | 1 | Invalid bit strobe |
| rx_wr | output | 1 | Load receive data register and set data-ready |
| rx_data | output | 8 | Byte for the receive data register |
| ovr_set | output | 1 | Set overrun flag |
| eod_set | output | 1 | Set end-of-data flag |
| crc_set | output | 1 | Set CRC error flag |
| ifd_set | output | 1 | Set invalid-frame flag |
| ibd_set | output | 1 | Set invalid-bit flag |
| brk_set | output | 1 | Set break flag |
| idle_set | output | 1 | Set idle flag |

## Verification
The assertions rely on three properties of the decoder input:
- At most one of `ev_sof`, `ev_byte` and `ev_eofmin` pulses in any cycle.
- `tx_active` is steady while an identifier byte is in flight.
- Map writes are not made in the cycle of an identifier byte.

The bench respects these by driving exactly one event per clock, changing levels only between events, and making every map write in a cycle of its own.

// File: rtl/idf_pkg.sv
package idf_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_WAIT_ID = 3'd1,
        S_PASS    = 3'd2,
        S_SLEEP   = 3'd3,
        S_DROP_RX = 3'd4,
        S_DROP_TX = 3'd5
    } idf_state_e;
endpackage

// File: rtl/idf_bitmap.sv
module idf_bitmap #(
    parameter int ID_W  = 8,
    parameter int REG_W = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    we,
    input  logic [$clog2((1<<ID_W)/REG_W)-1:0]      waddr,
    input  logic [REG_W-1:0]                        wdata,
    input  logic [ID_W-1:0]                         id,
    output logic                                    hit
);
    localparam int ENTRIES = 1 << ID_W;
    localparam int NREG    = ENTRIES / REG_W;
    localparam int ADDR_W  = $clog2(NREG);
    localparam int SEL_W   = $clog2(REG_W);

    logic [REG_W-1:0] map_q [NREG];

    // One register per group of REG_W identifiers.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                map_q[r] <= '0;
            else if (we && (waddr == ADDR_W'(r)))
                map_q[r] <= wdata;
        end
    end

    // Upper identifier bits pick the register, lower bits pick the bit in it.
    assign hit = map_q[id[ID_W-1 -: ADDR_W]][id[SEL_W-1:0]];
endmodule

// File: rtl/idf_fsm.sv
module idf_fsm
    import idf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_sof,
    input  logic       ev_byte,
    input  logic       ev_eofmin,
    input  logic       id_hit,
    input  logic       tx_active,
    input  logic       sleep_req,
    output idf_state_e state
);
    idf_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:    if (ev_sof) state_d = S_WAIT_ID;
            S_WAIT_ID: begin
                if (ev_eofmin)   state_d = S_IDLE;
                else if (ev_byte) begin
                    if (id_hit)         state_d = S_PASS;
                    else if (tx_active) state_d = S_DROP_TX;
                    else                state_d = S_DROP_RX;
                end
            end
            S_PASS: begin
                if (ev_eofmin)      state_d = S_IDLE;
                else if (sleep_req) state_d = S_SLEEP;
            end
            S_SLEEP, S_DROP_RX, S_DROP_TX:
                if (ev_eofmin) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end
endmodule

// File: rtl/idf_gate.sv
module idf_gate
    import idf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  idf_state_e        state,
    input  logic              id_hit,
    input  logic              sleep_req,
    input  logic              ev_byte,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              ev_break,
    input  logic              ev_idle,
    input  logic              ev_overrun,
    input  logic              ev_eod,
    input  logic              ev_err_crc,
    input  logic              ev_err_frame,
    input  logic              ev_err_bit,
    output logic              rx_wr,
    output logic [DATA_W-1:0] rx_data,
    output logic              ovr_set,
    output logic              eod_set,
    output logic              crc_set,
    output logic              ifd_set,
    output logic              ibd_set,
    output logic              brk_set,
    output logic              idle_set
);
    logic byte_ok;
    logic mute_data;
    logic mute_err;

    always_comb begin
        byte_ok   = 1'b0;
        mute_data = 1'b0;
        mute_err  = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_WAIT_ID: byte_ok = ev_byte && id_hit;
            S_PASS:    byte_ok = ev_byte && !sleep_req;
            S_SLEEP:   mute_data = 1'b1;
            S_DROP_TX: mute_data = 1'b1;
            S_DROP_RX: begin
                mute_data = 1'b1;
                mute_err  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_wr    <= 1'b0;
            rx_data  <= '0;
            ovr_set  <= 1'b0;
            eod_set  <= 1'b0;
            crc_set  <= 1'b0;
            ifd_set  <= 1'b0;
            ibd_set  <= 1'b0;
            brk_set  <= 1'b0;
            idle_set <= 1'b0;
        end else begin
            rx_wr    <= byte_ok;
            if (byte_ok) rx_data <= ev_data;
            ovr_set  <= ev_overrun   && !mute_data;
            eod_set  <= ev_eod       && !mute_data;
            crc_set  <= ev_err_crc   && !mute_err;
            ifd_set  <= ev_err_frame && !mute_err;
            ibd_set  <= ev_err_bit   && !mute_err;
            brk_set  <= ev_break;
            idle_set <= ev_idle;
        end
    end
endmodule

// File: rtl/idmsg_filter.sv
module idmsg_filter
    import idf_pkg::*;
#(
    parameter int ID_W  = 8,
    parameter int REG_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [$clog2((1<<ID_W)/REG_W)-1:0]   cfg_addr,
    input  logic [REG_W-1:0]                     cfg_wdata,
    input  logic                                 tx_active,
    input  logic                                 sleep_req,
    input  logic                                 ev_sof,
    input  logic                                 ev_byte,
    input  logic [ID_W-1:0]                      ev_data,
    input  logic                                 ev_eofmin,
    input  logic                                 ev_break,
    input  logic                                 ev_idle,
    input  logic                                 ev_overrun,
    input  logic                                 ev_eod,
    input  logic                                 ev_err_crc,
    input  logic                                 ev_err_frame,
    input  logic                                 ev_err_bit,
    output logic                                 rx_wr,
    output logic [ID_W-1:0]                      rx_data,
    output logic                                 ovr_set,
    output logic                                 eod_set,
    output logic                                 crc_set,
    output logic                                 ifd_set,
    output logic                                 ibd_set,
    output logic                                 brk_set,
    output logic                                 idle_set
);
    logic       id_hit;
    idf_state_e state;

    idf_bitmap #(.ID_W(ID_W), .REG_W(REG_W)) u_map (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wdata(cfg_wdata), .id(ev_data), .hit(id_hit)
    );

    idf_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ev_sof(ev_sof), .ev_byte(ev_byte),
        .ev_eofmin(ev_eofmin), .id_hit(id_hit), .tx_active(tx_active),
        .sleep_req(sleep_req), .state(state)
    );

    idf_gate #(.DATA_W(ID_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .state(state), .id_hit(id_hit),
        .sleep_req(sleep_req), .ev_byte(ev_byte), .ev_data(ev_data),
        .ev_break(ev_break), .ev_idle(ev_idle), .ev_overrun(ev_overrun),
        .ev_eod(ev_eod), .ev_err_crc(ev_err_crc), .ev_err_frame(ev_err_frame),
        .ev_err_bit(ev_err_bit), .rx_wr(rx_wr), .rx_data(rx_data),
        .ovr_set(ovr_set), .eod_set(eod_set), .crc_set(crc_set),
        .ifd_set(ifd_set), .ibd_set(ibd_set), .brk_set(brk_set),
        .idle_set(idle_set)
    );
endmodule

// File: rtl/idmsg_filter_chk.sv
module idmsg_filter_chk
    import idf_pkg::*;
#(
    parameter int ID_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input idf_state_e      state,
    input logic            id_hit,
    input logic            tx_active,
    input logic            ev_byte,
    input logic [ID_W-1:0] ev_data,
    input logic            ev_eofmin,
    input logic            ev_break,
    input logic            ev_err_crc,
    input logic            rx_wr,
    input logic [ID_W-1:0] rx_data,
    input logic            ovr_set,
    input logic            eod_set,
    input logic            crc_set,
    input logic            ifd_set,
    input logic            ibd_set,
    input logic            brk_set
);
    a_r3_accept_loads_id: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ID && ev_byte && id_hit) |=> (rx_wr && rx_data == $past(ev_data)));

    a_r5_reject_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ID && ev_byte && !id_hit) |=> !rx_wr);

    a_r5_drop_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP_RX) |=> (!rx_wr && !ovr_set && !eod_set && !crc_set && !ifd_set && !ibd_set));

    a_r6_break_forward: assert property (@(posedge clk) disable iff (!rst_n)
        ev_break |=> brk_set);

    a_r8_eof_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        ev_eofmin |=> (state == S_IDLE));

    a_r9_own_tx_crc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP_TX && ev_err_crc) |=> crc_set);

    a_r9_own_tx_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ID && ev_byte && !id_hit && tx_active) |=> (state == S_DROP_TX));
endmodule

bind idmsg_filter idmsg_filter_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .id_hit(id_hit),
    .tx_active(tx_active), .ev_byte(ev_byte), .ev_data(ev_data),
    .ev_eofmin(ev_eofmin), .ev_break(ev_break), .ev_err_crc(ev_err_crc),
    .rx_wr(rx_wr), .rx_data(rx_data), .ovr_set(ovr_set), .eod_set(eod_set),
    .crc_set(crc_set), .ifd_set(ifd_set), .ibd_set(ibd_set), .brk_set(brk_set)
);

// File: tb/idmsg_filter_bench.sv
`timescale 1ns/1ps
module idmsg_filter_bench;
    localparam int K_SOF = 0, K_BYTE = 1, K_EOF = 2, K_BRK = 3, K_IDLE = 4,
                   K_OVR = 5, K_EOD = 6, K_CRC = 7, K_IFD = 8, K_IBD = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       tx_active = 1'b0, sleep_req = 1'b0;
    logic       ev_sof = 1'b0, ev_byte = 1'b0, ev_eofmin = 1'b0, ev_break = 1'b0;
    logic       ev_idle = 1'b0, ev_overrun = 1'b0, ev_eod = 1'b0;
    logic       ev_err_crc = 1'b0, ev_err_frame = 1'b0, ev_err_bit = 1'b0;
    logic [7:0] ev_data = '0;
    logic       rx_wr, ovr_set, eod_set, crc_set, ifd_set, ibd_set, brk_set, idle_set;
    logic [7:0] rx_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    always #5 clk = ~clk;

    idmsg_filter u_idmsg_filter (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_active(tx_active), .sleep_req(sleep_req),
        .ev_sof(ev_sof), .ev_byte(ev_byte), .ev_data(ev_data),
        .ev_eofmin(ev_eofmin), .ev_break(ev_break), .ev_idle(ev_idle),
        .ev_overrun(ev_overrun), .ev_eod(ev_eod), .ev_err_crc(ev_err_crc),
        .ev_err_frame(ev_err_frame), .ev_err_bit(ev_err_bit),
        .rx_wr(rx_wr), .rx_data(rx_data), .ovr_set(ovr_set), .eod_set(eod_set),
        .crc_set(crc_set), .ifd_set(ifd_set), .ibd_set(ibd_set),
        .brk_set(brk_set), .idle_set(idle_set)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        {ev_sof, ev_byte, ev_eofmin, ev_break, ev_idle, ev_overrun} = '0;
        {ev_eod, ev_err_crc, ev_err_frame, ev_err_bit, cfg_we} = '0;
    endtask

    // One event per cycle; outputs are sampled 1 ns after the edge that registers it.
    task automatic ev(input int kind, input logic [7:0] d = 8'h00);
        @(negedge clk);
        clr();
        case (kind)
            K_SOF:  ev_sof = 1'b1;
            K_BYTE: begin ev_byte = 1'b1; ev_data = d; end
            K_EOF:  ev_eofmin = 1'b1;
            K_BRK:  ev_break = 1'b1;
            K_IDLE: ev_idle = 1'b1;
            K_OVR:  ev_overrun = 1'b1;
            K_EOD:  ev_eod = 1'b1;
            K_CRC:  ev_err_crc = 1'b1;
            K_IFD:  ev_err_frame = 1'b1;
            default: ev_err_bit = 1'b1;
        endcase
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        clr();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 rx_wr after reset", 16'(rx_wr), 16'd0);
        chk("R1 flags after reset",
            16'({ovr_set, eod_set, crc_set, ifd_set, ibd_set, brk_set, idle_set}), 16'd0);
        ev(K_SOF); ev(K_BYTE, 8'h10);
        chk("R1 all ids rejected", 16'(rx_wr), 16'd0);
        ev(K_EOF);
    endtask

    task automatic t_map();
        wr(5'd2, 8'h01); wr(5'd31, 8'h80); wr(5'd0, 8'h01);
        ev(K_SOF); ev(K_BYTE, 8'h10);
        chk("R2 id 0x10 reg2 bit0", 16'({rx_wr, rx_data}), 16'h110);
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'hFF);
        chk("R2 id 0xFF reg31 bit7", 16'({rx_wr, rx_data}), 16'h1FF);
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'h00);
        chk("R2 id 0x00 reg0 bit0", 16'({rx_wr, rx_data}), 16'h100);
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'h11);
        chk("R2 id 0x11 neighbour rejected", 16'(rx_wr), 16'd0);
        ev(K_EOF);
    endtask

    task automatic t_accept();
        ev(K_BYTE, 8'h10);
        chk("R3 byte outside frame dropped", 16'(rx_wr), 16'd0);
        ev(K_SOF); ev(K_BYTE, 8'h10);
        chk("R3 id transferred", 16'({rx_wr, rx_data}), 16'h110);
        ev(K_BYTE, 8'hAB);
        chk("R4 data byte transferred", 16'({rx_wr, rx_data}), 16'h1AB);
        ev(K_OVR); chk("R4 overrun forwarded", 16'(ovr_set), 16'd1);
        ev(K_EOD); chk("R4 eod forwarded", 16'(eod_set), 16'd1);
        ev(K_CRC); chk("R4 crc forwarded", 16'(crc_set), 16'd1);
        wr(5'd2, 8'h03);   // mid-frame write, used by next frame
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'h11);
        chk("R2 write seen by next lookup", 16'({rx_wr, rx_data}), 16'h111);
        ev(K_EOF);
        wr(5'd2, 8'h01);
    endtask

    task automatic t_reject_rx();
        ev(K_SOF);
        ev(K_IBD); chk("R7 ibd before compare", 16'(ibd_set), 16'd1);
        ev(K_IFD); chk("R7 ifd before compare", 16'(ifd_set), 16'd1);
        ev(K_BYTE, 8'h11); chk("R5 rejected id no load", 16'(rx_wr), 16'd0);
        ev(K_BYTE, 8'h22); chk("R5 later byte dropped", 16'(rx_wr), 16'd0);
        ev(K_CRC); chk("R5 crc muted", 16'(crc_set), 16'd0);
        ev(K_IBD); chk("R5 ibd muted", 16'(ibd_set), 16'd0);
        ev(K_IFD); chk("R5 ifd muted", 16'(ifd_set), 16'd0);
        ev(K_EOD); chk("R5 eod muted", 16'(eod_set), 16'd0);
        ev(K_OVR); chk("R5 ovr muted", 16'(ovr_set), 16'd0);
        ev(K_BRK); chk("R6 break in rejected frame", 16'(brk_set), 16'd1);
        ev(K_IDLE); chk("R6 idle in rejected frame", 16'(idle_set), 16'd1);
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'h10);
        chk("R8 re-armed after eofmin", 16'({rx_wr, rx_data}), 16'h110);
        ev(K_EOF);
    endtask

    task automatic t_own_tx();
        tx_active = 1'b1;
        ev(K_SOF); ev(K_BYTE, 8'h11);
        chk("R9 own rejected id no load", 16'(rx_wr), 16'd0);
        ev(K_BYTE, 8'h33); chk("R9 own byte no load", 16'(rx_wr), 16'd0);
        ev(K_CRC); chk("R9 crc kept", 16'(crc_set), 16'd1);
        ev(K_IBD); chk("R9 ibd kept", 16'(ibd_set), 16'd1);
        ev(K_IFD); chk("R9 ifd kept", 16'(ifd_set), 16'd1);
        ev(K_BRK); chk("R9 break kept", 16'(brk_set), 16'd1);
        ev(K_OVR); chk("R9 ovr muted", 16'(ovr_set), 16'd0);
        ev(K_EOD); chk("R9 eod muted", 16'(eod_set), 16'd0);
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'hFF);
        chk("R10 own accepted id looped", 16'({rx_wr, rx_data}), 16'h1FF);
        ev(K_BYTE, 8'h5A);
        chk("R10 own byte looped", 16'({rx_wr, rx_data}), 16'h15A);
        ev(K_EOF);
        tx_active = 1'b0;
    endtask

    task automatic t_sleep();
        ev(K_SOF); ev(K_BYTE, 8'h10);
        chk("R11 id before sleep", 16'(rx_wr), 16'd1);
        sleep_req = 1'b1;
        ev(K_BYTE, 8'h55); chk("R11 byte with sleep dropped", 16'(rx_wr), 16'd0);
        sleep_req = 1'b0;
        ev(K_BYTE, 8'h66); chk("R11 stays asleep", 16'(rx_wr), 16'd0);
        ev(K_EOD); chk("R11 eod muted", 16'(eod_set), 16'd0);
        ev(K_CRC); chk("R11 crc kept", 16'(crc_set), 16'd1);
        ev(K_EOF);
        ev(K_SOF); ev(K_BYTE, 8'h10);
        chk("R11 R8 next frame after sleep", 16'({rx_wr, rx_data}), 16'h110);
        ev(K_EOF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_map();
        t_accept();
        t_reject_rx();
        t_own_tx();
        t_sleep();
        repeat (2) @(posedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule